// File: doc/BRIEF.md
# Prescaled Free-Running Timer

This block is a 16-bit up-counter that steps once per count tick. A free-running prescaler makes the ticks from the system clock, and a 3-bit select sets the divide ratio to a power of two from 1 to 128. An 8-bit control byte holds the following:

- an overflow flag
- an interrupt enable
- a stop bit
- a compare-clear mode bit
- a write-only clear strobe
- the divide select

A separate 16-bit write port loads the counter while the timer is stopped. An external compare-match pulse can reset the counter when the compare-clear mode bit is set. The interrupt line is high while a pending overflow is enabled.

Software reads the control byte through a combinational read port. A read-modify-write qualifier forces the flag bit to read as 1. As a result, a read-modify-write sequence that changes some other field writes the flag bit back as 1 and leaves a pending overflow in place. Writing 0 to the flag bit is the only way to drop it.

Top module: `ptimer_top`

## Requirements
- R1: While reset is asserted, the counter value is 0x0000, the control byte reads 0x00 and irq is 0.
- R2: With the stop bit (bit 5) at 0, the counter adds one on every count tick. With it at 1, the counter holds its value.
- R3: Select bits [2:0] = n give one count tick every 2^n system clocks. A 7-bit prescaler counts every clock from reset, and a tick falls on each cycle where its value mod 2^n equals 2^n-1. A new select value applies from the cycle after the write.
- R4: A step from 0xFFFF to 0x0000 sets the overflow flag (bit 7).
- R5: Writing a control byte with bit 7 = 0 clears the flag, and bit 7 = 1 leaves it unchanged. An overflow in the same cycle as a clearing write leaves the flag set.
- R6: With the read-modify-write qualifier high, bit 7 of the control read is 1. With it low, bit 7 shows the flag.
- R7: irq equals the overflow flag ANDed with the enable bit (bit 6).
- R8: A control write with bit 3 = 1 makes the counter 0x0000 on the next cycle, and bit 3 = 0 does nothing. Bit 3 always reads 0.
- R9: With the mode bit (bit 4) at 1, a compare-match pulse makes the counter 0x0000 on the next cycle. With it at 0, the pulse is ignored.
- R10: A data write loads the counter on the next cycle if the stop bit is 1 in that cycle. While the timer is running, a data write is ignored.
- R11: When events coincide, they apply in this order: software clear, then compare clear, then data load, then count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write value |
| ctl_rmw | input | 1 | Read-modify-write qualifier for the control read |
| ctl_rdata | output | 8 | Control byte read value |
| cnt_wr | input | 1 | Counter data write strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| cnt_value | output | CNT_W | Current counter value |
| cmp_match | input | 1 | Compare-match pulse from an external comparator |
| irq | output | 1 | Interrupt request |

## Verification
Each internal fault reaches a port within a known number of cycles:

- A prescaler phase error or a wrong divide decode changes the counter value within 2^n clocks, because the step lands on a different cycle.
- A lost or stuck overflow flag appears on ctl_rdata bit 7 and on irq in the cycle after the wrap.
- A wrong priority between clear, compare, load and step puts a different counter value on cnt_value on the very next cycle.

For these reasons, the bench compares every output on every clock against a behavioural model, so the first wrong cycle is reported.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int SEL_W  = 3;
  localparam int PRE_W  = (1 << SEL_W) - 1;
  localparam int CTL_W  = 8;
  localparam int B_FLAG = 7;
  localparam int B_IEN  = 6;
  localparam int B_STOP = 5;
  localparam int B_MODE = 4;
  localparam int B_CLR  = 3;

  typedef struct packed {
    logic             flag;
    logic             ien;
    logic             stop;
    logic             mode;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  // tick when the low `sel` bits of the prescaler are all ones
  function automatic logic tick_due(input logic [PRE_W-1:0] pre,
                                    input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] mask;
    mask = PRE_W'((1 << sel) - 1);
    return (pre & mask) == mask;
  endfunction

  // read image of the control byte; rmw forces the flag to read as set
  function automatic logic [CTL_W-1:0] ctl_read(input ctl_t c, input logic rmw);
    return {c.flag | rmw, c.ien, c.stop, c.mode, 1'b0, c.sel};
  endfunction
endpackage

// File: rtl/ptimer_prescale.sv
module ptimer_prescale
  import ptimer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick = tick_due(pre_q, sel);
endmodule

// File: rtl/ptimer_ctrl.sv
module ptimer_ctrl
  import ptimer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             rmw,
  input  logic             wrap_evt,
  output ctl_t             ctl,
  output logic             sw_clr,
  output logic [CTL_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (wr) begin
        ctl.ien  <= wdata[B_IEN];
        ctl.stop <= wdata[B_STOP];
        ctl.mode <= wdata[B_MODE];
        ctl.sel  <= wdata[SEL_W-1:0];
      end
      // a fresh overflow outranks a clearing write
      if (wrap_evt)                 ctl.flag <= 1'b1;
      else if (wr && !wdata[B_FLAG]) ctl.flag <= 1'b0;
    end
  end

  assign sw_clr = wr & wdata[B_CLR];
  assign rdata  = ctl_read(ctl, rmw);
endmodule

// File: rtl/ptimer_count.sv
module ptimer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             sw_clr,
  input  logic             cmp_clr,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_data,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic advance;
  assign advance  = tick & run & ~sw_clr & ~cmp_clr & ~load;
  assign wrap_evt = advance & (cnt == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (sw_clr)  cnt <= '0;
    else if (cmp_clr) cnt <= '0;
    else if (load)    cnt <= ld_data;
    else if (advance) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             ctl_rmw,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_value,
  input  logic             cmp_match,
  output logic             irq
);
  ctl_t ctl;
  logic tick;
  logic wrap_evt;
  logic sw_clr;
  logic cmp_clr;
  logic load_en;
  logic flag_q;

  assign cmp_clr = ctl.mode & cmp_match;
  assign load_en = cnt_wr & ctl.stop;
  assign flag_q  = ctl.flag;
  assign irq     = ctl.flag & ctl.ien;

  ptimer_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (ctl.sel),
    .tick  (tick)
  );

  ptimer_ctrl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .wdata    (ctl_wdata),
    .rmw      (ctl_rmw),
    .wrap_evt (wrap_evt),
    .ctl      (ctl),
    .sw_clr   (sw_clr),
    .rdata    (ctl_rdata)
  );

  ptimer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (~ctl.stop),
    .sw_clr   (sw_clr),
    .cmp_clr  (cmp_clr),
    .load     (load_en),
    .ld_data  (cnt_wdata),
    .cnt      (cnt_value),
    .wrap_evt (wrap_evt)
  );
endmodule

// File: rtl/ptimer_chk.sv
module ptimer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [7:0]       ctl_wdata,
  input logic             ctl_rmw,
  input logic [7:0]       ctl_rdata,
  input logic             cnt_wr,
  input logic             cmp_match,
  input logic [CNT_W-1:0] cnt_value,
  input logic             irq,
  input logic             tick,
  input logic             wrap_evt,
  input logic             flag_q
);
  assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[5] && !ctl_wr && !cnt_wr && !cmp_match |=> $stable(cnt_value));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[5] && tick && !ctl_wr && !cmp_match && (cnt_value != '1)
    |=> cnt_value == CNT_W'($past(cnt_value) + 1'b1));

  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !ctl_wr && !cnt_wr && !cmp_match |=> $stable(cnt_value));

  assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_q);

  assert_rmw_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rmw |-> ctl_rdata[7]);

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctl_rdata[6] && flag_q));

  assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[3] |=> cnt_value == '0);

  assert_clr_bit_reads_0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[3]);

  assert_cmp_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[4] && cmp_match |=> cnt_value == '0);
endmodule

bind ptimer_top ptimer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .ctl_rmw   (ctl_rmw),
  .ctl_rdata (ctl_rdata),
  .cnt_wr    (cnt_wr),
  .cmp_match (cmp_match),
  .cnt_value (cnt_value),
  .irq       (irq),
  .tick      (tick),
  .wrap_evt  (wrap_evt),
  .flag_q    (flag_q)
);

// File: tb/ptimer_tb.sv
`timescale 1ns/1ps
module ptimer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        ctl_rmw = 1'b0;
  logic [7:0]  ctl_rdata;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic [15:0] cnt_value;
  logic        cmp_match = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  ptimer_top #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rmw(ctl_rmw), .ctl_rdata(ctl_rdata), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .cnt_value(cnt_value), .cmp_match(cmp_match),
    .irq(irq)
  );

  // behavioural reference model
  int m_cnt, m_pre, m_sel, m_div, m_next;
  bit m_flag, m_ien, m_stop, m_mode, m_tick, m_wrap, m_nflag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_sel = 0;
      m_flag = 0; m_ien = 0; m_stop = 0; m_mode = 0;
    end else begin
      m_div  = 1 << m_sel;
      m_tick = (m_pre % m_div) == (m_div - 1);
      m_next = m_cnt;
      m_wrap = 0;
      if (ctl_wr && ctl_wdata[3])      m_next = 0;
      else if (m_mode && cmp_match)    m_next = 0;
      else if (cnt_wr && m_stop)       m_next = int'(cnt_wdata);
      else if (m_tick && !m_stop) begin
        if (m_cnt == 65535) begin m_next = 0; m_wrap = 1; end
        else m_next = m_cnt + 1;
      end
      m_nflag = m_flag;
      if (ctl_wr && !ctl_wdata[7]) m_nflag = 0;
      if (m_wrap) m_nflag = 1;
      if (ctl_wr) begin
        m_ien = ctl_wdata[6]; m_stop = ctl_wdata[5];
        m_mode = ctl_wdata[4]; m_sel = int'(ctl_wdata[2:0]);
      end
      m_pre  = (m_pre + 1) % 128;
      m_cnt  = m_next;
      m_flag = m_nflag;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check({phase, " cnt"}, 32'(cnt_value), 32'(m_cnt));
      check({phase, " ctl"}, 32'(ctl_rdata),
            32'({m_flag | ctl_rmw, m_ien, m_stop, m_mode, 1'b0, 3'(m_sel)}));
      check({phase, " irq"}, 32'(irq), 32'(m_flag & m_ien));
    end
  end

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [15:0] v);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic pulse_cmp();
    @(negedge clk); cmp_match = 1'b1;
    @(negedge clk); cmp_match = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    check("R1 cnt", 32'(cnt_value), 32'h0);
    check("R1 ctl", 32'(ctl_rdata), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    phase = "R2";
    repeat (10) @(negedge clk);

    phase = "R10";
    wr_ctl(8'h20);
    wr_data(16'h1234);
    check("R10 load while stopped", 32'(cnt_value), 32'h1234);
    repeat (3) @(negedge clk);
    check("R2 hold while stopped", 32'(cnt_value), 32'h1234);
    wr_ctl(8'h00);
    check("R2 no step in restart cycle", 32'(cnt_value), 32'h1234);
    repeat (5) @(negedge clk);
    check("R2 run", 32'(cnt_value), 32'h1239);
    wr_data(16'h0100);
    check("R10 load ignored while running", 32'(cnt_value), 32'h123B);

    phase = "R8";
    wr_ctl(8'h08);
    check("R8 sw clear beats tick", 32'(cnt_value), 32'h0);
    check("R8 clear bit reads 0", 32'(ctl_rdata), 32'h0);

    phase = "R9";
    pulse_cmp();
    check("R9 compare ignored in mode 0", 32'(cnt_value), 32'h2);
    wr_ctl(8'h10);
    repeat (3) @(negedge clk);
    pulse_cmp();
    check("R9 compare clears in mode 1", 32'(cnt_value), 32'h0);
    wr_ctl(8'h00);

    phase = "R3";
    wr_ctl(8'h02);
    c0 = cnt_value;
    repeat (40) @(negedge clk);
    check("R3 divide by 4", 32'(cnt_value), 32'(c0 + 16'd10));
    wr_ctl(8'h07);
    c0 = cnt_value;
    repeat (128) @(negedge clk);
    check("R3 divide by 128", 32'(cnt_value), 32'(c0 + 16'd1));
    wr_ctl(8'h05);
    repeat (100) @(negedge clk);
    wr_ctl(8'h00);

    phase = "R4";
    wr_ctl(8'h60);
    wr_data(16'hFFFE);
    wr_ctl(8'h40);
    repeat (2) @(negedge clk);
    check("R4 wrap to zero", 32'(cnt_value), 32'h0);
    check("R4 flag set", 32'(ctl_rdata), 32'hC0);
    check("R7 irq with enable", 32'(irq), 32'h1);
    phase = "R5";
    wr_ctl(8'hC0);
    check("R5 write 1 keeps flag", 32'(ctl_rdata), 32'hC0);
    wr_ctl(8'h80);
    check("R7 flag kept", 32'(ctl_rdata), 32'h80);
    check("R7 irq masked", 32'(irq), 32'h0);
    wr_ctl(8'h40);
    check("R5 write 0 clears flag", 32'(ctl_rdata), 32'h40);
    check("R7 irq low after clear", 32'(irq), 32'h0);
    phase = "R6";
    ctl_rmw = 1'b1; #1;
    check("R6 rmw reads flag as 1", 32'(ctl_rdata), 32'hC0);
    ctl_rmw = 1'b0; #1;
    check("R6 plain read shows flag", 32'(ctl_rdata), 32'h40);

    phase = "R5";
    wr_ctl(8'h20);
    wr_data(16'hFFFE);
    wr_ctl(8'h00);
    wr_ctl(8'h00);
    check("R5 overflow beats clear", 32'(ctl_rdata), 32'h80);
    check("R4 wrapped", 32'(cnt_value), 32'h0);
    wr_ctl(8'h00);

    phase = "R11";
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = 8'h18; cmp_match = 1'b1;
    cnt_wr = 1'b1; cnt_wdata = 16'h5555;
    @(negedge clk);
    ctl_wr = 1'b0; cmp_match = 1'b0; cnt_wr = 1'b0;
    check("R11 sw clear first", 32'(cnt_value), 32'h0);
    wr_ctl(8'h30);
    @(negedge clk);
    cnt_wr = 1'b1; cnt_wdata = 16'h5555; cmp_match = 1'b1;
    @(negedge clk);
    cnt_wr = 1'b0; cmp_match = 1'b0;
    check("R11 compare beats load", 32'(cnt_value), 32'h0);
    wr_data(16'h5555);
    check("R10 load in mode 1", 32'(cnt_value), 32'h5555);
    wr_ctl(8'h00);

    phase = "R11 random";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ctl_wr    = ($urandom % 12) == 0;
      ctl_wdata = 8'($urandom);
      cnt_wr    = ($urandom % 6) == 0;
      cnt_wdata = ($urandom % 2) ? (16'hFFF0 | 16'($urandom % 16)) : 16'($urandom);
      cmp_match = ($urandom % 10) == 0;
      ctl_rmw   = ($urandom % 4) == 0;
    end
    @(negedge clk);
    ctl_wr = 1'b0; cnt_wr = 1'b0; cmp_match = 1'b0; ctl_rmw = 1'b0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule